// File: doc/BRIEF.md
# Debugger-to-CPU Two-Way Mailbox

This block carries single 32-bit words between an external debugger and the on-chip CPU. It has two independent one-word channels. The debug-to-CPU channel is written by the debugger and read by the CPU. The CPU-to-debug channel is written by the CPU and read by the debugger. Each channel holds one data word and one pending flag. The same flag can be read from both sides: the writing side sees it as its transmit status, and the reading side sees it as its receive status.

Each side has a plain register bus made of an address, a write enable, a read strobe, write data and read data. Read data is combinational from the address presented. Writes and read side effects take effect at the next rising clock edge. The register buses have no valid/ready handshake and apply no back-pressure: a sender may overwrite a word the receiver has not yet taken. The pending flag is how software avoids doing so. One clock drives both sides.

Top module: `dbg_cpu_mailbox`

## Requirements
- R1: After reset every data and status register reads as 0x00000000 on both sides.
- R2: A debugger write to 0x020 stores the word. From the next cycle, bit 0 of debugger 0x024 and bit 0 of CPU 0x404 both read 1, and CPU 0x400 and debugger 0x020 return the word.
- R3: A CPU write to 0x480 stores the word. From the next cycle, bit 0 of CPU 0x484 and bit 0 of debugger 0x02C both read 1, and debugger 0x028 and CPU 0x480 return the word.
- R4: A CPU read of 0x400, marked by the read strobe, returns the word. From the next cycle, CPU 0x404 and debugger 0x024 both read 0.
- R5: A debugger read of 0x028 returns the word. From the next cycle, debugger 0x02C and CPU 0x484 both read 0.
- R6: Reading any status register has no side effect, and neither does a sender reading back its own transmit data register. A pending flag stays 1 through such reads.
- R7: A sender write while its channel is already pending replaces the stored word and leaves the flag at 1.
- R8: A receiver data read and a sender write in the same cycle on one channel do two things. The read returns the old word, and afterwards the flag is 1 and the new word is stored.
- R9: Writes to status registers, to receive data registers or to unmapped addresses change no data and no flag.
- R10: A status read returns the flag in bit 0 and zeros in bits 31:1. A read of an address outside a side's own map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_addr | input | 12 | Debugger-side register address |
| dbg_we | input | 1 | Debugger write enable |
| dbg_re | input | 1 | Debugger read strobe |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data, combinational from dbg_addr |
| cpu_addr | input | 12 | CPU-side register address |
| cpu_we | input | 1 | CPU write enable |
| cpu_re | input | 1 | CPU read strobe |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, combinational from cpu_addr |

## Verification
The assertions check the flag rules on every cycle for both channels:
- a sender write always leaves the flag set and the word captured;
- a receiver take without a write always clears the flag;
- with neither event, the flag and the word stay unchanged;
- status reads and misdirected writes never move channel state.

Some behaviour is only shown by the bench's scenarios, through the address maps:
- that each flag appears at the right status address on both sides;
- that the old word is returned in a collision cycle;
- that unmapped and read-only addresses read as specified.

// File: rtl/dbgmbx_pkg.sv
package dbgmbx_pkg;
  localparam int unsigned MBX_DATA_W = 32;
  localparam int unsigned MBX_ADDR_W = 12;

  // debugger-side map
  localparam int unsigned DBG_TX_DATA = 'h020;
  localparam int unsigned DBG_TX_STAT = 'h024;
  localparam int unsigned DBG_RX_DATA = 'h028;
  localparam int unsigned DBG_RX_STAT = 'h02C;

  // CPU-side map
  localparam int unsigned CPU_RX_DATA = 'h400;
  localparam int unsigned CPU_RX_STAT = 'h404;
  localparam int unsigned CPU_TX_DATA = 'h480;
  localparam int unsigned CPU_TX_STAT = 'h484;
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [DATA_W-1:0] put_word,
  input  logic              take,
  output logic [DATA_W-1:0] word_q,
  output logic              full_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (put) word_q <= put_word;
      if (put)       full_q <= 1'b1;   // writer wins over a same-cycle take
      else if (take) full_q <= 1'b0;
    end
  end

  // R2 / R3 / R7: a put always leaves the word captured and the flag set
  a_r2_put_sets: assert property (@(posedge clk) disable iff (!rst_n)
    put |=> (full_q && word_q == $past(put_word)));

  // R8: a collision of put and take keeps the flag set
  a_r8_put_beats_take: assert property (@(posedge clk) disable iff (!rst_n)
    (put && take) |=> full_q);

  // R4 / R5: a take without a put empties the channel
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !put) |=> !full_q);

  // R6: with no event, the state holds
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !put) |=> ($stable(full_q) && $stable(word_q)));
endmodule

// File: rtl/mbx_port.sv
module mbx_port #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned A_TXD   = 0,
  parameter int unsigned A_TXS   = 4,
  parameter int unsigned A_RXD   = 8,
  parameter int unsigned A_RXS   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_full,
  output logic              tx_put,
  output logic              rx_take,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] TXD = ADDR_W'(A_TXD);
  localparam logic [ADDR_W-1:0] TXS = ADDR_W'(A_TXS);
  localparam logic [ADDR_W-1:0] RXD = ADDR_W'(A_RXD);
  localparam logic [ADDR_W-1:0] RXS = ADDR_W'(A_RXS);

  logic hit_txd, hit_txs, hit_rxd, hit_rxs;

  always_comb begin
    hit_txd = (addr == TXD);
    hit_txs = (addr == TXS);
    hit_rxd = (addr == RXD);
    hit_rxs = (addr == RXS);
    tx_put  = we && hit_txd;
    rx_take = re && hit_rxd;
    rdata   = '0;
    if (hit_txd) rdata = tx_word;
    if (hit_rxd) rdata = rx_word;
    if (hit_txs) rdata = {{(DATA_W-1){1'b0}}, tx_full};
    if (hit_rxs) rdata = {{(DATA_W-1){1'b0}}, rx_full};
  end

  // R10: status reads carry nothing above bit 0
  always_comb begin
    if (hit_txs || hit_rxs)
      a_r10_status_upper_zero: assert (rdata[DATA_W-1:1] == '0);
  end
endmodule

// File: rtl/dbg_cpu_mailbox.sv
module dbg_cpu_mailbox
  import dbgmbx_pkg::*;
#(
  parameter int unsigned ADDR_W = MBX_ADDR_W,
  parameter int unsigned DATA_W = MBX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_we,
  input  logic              dbg_re,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int unsigned NCH = 2;   // 0: debug->CPU, 1: CPU->debug

  logic [DATA_W-1:0] ch_word [NCH];
  logic              ch_full [NCH];
  logic              ch_put  [NCH];
  logic              ch_take [NCH];
  logic [DATA_W-1:0] ch_in   [NCH];

  logic dbg_put, dbg_take, cpu_put, cpu_take;

  mbx_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_TXD(DBG_TX_DATA), .A_TXS(DBG_TX_STAT),
    .A_RXD(DBG_RX_DATA), .A_RXS(DBG_RX_STAT)
  ) u_dbg_port (
    .addr(dbg_addr), .we(dbg_we), .re(dbg_re),
    .tx_word(ch_word[0]), .tx_full(ch_full[0]),
    .rx_word(ch_word[1]), .rx_full(ch_full[1]),
    .tx_put(dbg_put), .rx_take(dbg_take), .rdata(dbg_rdata)
  );

  mbx_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_TXD(CPU_TX_DATA), .A_TXS(CPU_TX_STAT),
    .A_RXD(CPU_RX_DATA), .A_RXS(CPU_RX_STAT)
  ) u_cpu_port (
    .addr(cpu_addr), .we(cpu_we), .re(cpu_re),
    .tx_word(ch_word[1]), .tx_full(ch_full[1]),
    .rx_word(ch_word[0]), .rx_full(ch_full[0]),
    .tx_put(cpu_put), .rx_take(cpu_take), .rdata(cpu_rdata)
  );

  always_comb begin
    ch_put[0]  = dbg_put;   ch_take[0] = cpu_take; ch_in[0] = dbg_wdata;
    ch_put[1]  = cpu_put;   ch_take[1] = dbg_take; ch_in[1] = cpu_wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbx_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .put(ch_put[g]), .put_word(ch_in[g]), .take(ch_take[g]),
      .word_q(ch_word[g]), .full_q(ch_full[g])
    );
  end

  // R6: a CPU status read with no debugger data write leaves the flag alone
  a_r6_status_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && cpu_addr == ADDR_W'(CPU_RX_STAT) &&
     !(dbg_we && dbg_addr == ADDR_W'(DBG_TX_DATA)))
    |=> (ch_full[0] == $past(ch_full[0])));

  // R9: a debugger write anywhere but its transmit data leaves that word alone
  a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && dbg_addr != ADDR_W'(DBG_TX_DATA)) |=> $stable(ch_word[0]));
endmodule

// File: tb/test_dbg_cpu_mailbox.sv
module test_dbg_cpu_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] dbg_addr = '0, cpu_addr = '0;
  logic        dbg_we = 1'b0, dbg_re = 1'b0, cpu_we = 1'b0, cpu_re = 1'b0;
  logic [31:0] dbg_wdata = '0, cpu_wdata = '0;
  logic [31:0] dbg_rdata, cpu_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cpu_mailbox i_dbg_cpu_mailbox (
    .clk(clk), .rst_n(rst_n),
    .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_re(dbg_re),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // side 0 = debugger, side 1 = CPU; one cycle, effect at the middle posedge
  task automatic wr(bit side, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    if (!side) begin dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1; end
    else       begin cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; end
    @(negedge clk);
    dbg_we = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd(bit side, logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    if (!side) begin dbg_addr = a; dbg_re = 1'b1; end
    else       begin cpu_addr = a; cpu_re = 1'b1; end
    #1;
    d = side ? cpu_rdata : dbg_rdata;
    @(negedge clk);
    dbg_re = 1'b0; cpu_re = 1'b0;
  endtask

  task automatic rd_chk(bit side, logic [11:0] a, logic [31:0] exp, string req);
    logic [31:0] v;
    rd(side, a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk(0, 12'h024, 0, "R1 dbg txs");
    rd_chk(0, 12'h02C, 0, "R1 dbg rxs");
    rd_chk(0, 12'h020, 0, "R1 dbg txd");
    rd_chk(0, 12'h028, 0, "R1 dbg rxd");
    rd_chk(1, 12'h404, 0, "R1 cpu rxs");
    rd_chk(1, 12'h484, 0, "R1 cpu txs");
    rd_chk(1, 12'h400, 0, "R1 cpu rxd");
    rd_chk(1, 12'h480, 0, "R1 cpu txd");
  endtask

  task automatic t_dbg_to_cpu;
    wr(0, 12'h020, 32'hA5A5_0001);
    rd_chk(0, 12'h024, 1, "R2 dbg txs set");
    rd_chk(1, 12'h404, 1, "R2 cpu rxs set");
    rd_chk(0, 12'h020, 32'hA5A5_0001, "R2 dbg txd readback");
    rd_chk(1, 12'h400, 32'hA5A5_0001, "R4 cpu rxd word");
    rd_chk(1, 12'h404, 0, "R4 cpu rxs cleared");
    rd_chk(0, 12'h024, 0, "R4 dbg txs cleared");
  endtask

  task automatic t_cpu_to_dbg;
    wr(1, 12'h480, 32'h1234_5678);
    rd_chk(1, 12'h484, 1, "R3 cpu txs set");
    rd_chk(0, 12'h02C, 1, "R3 dbg rxs set");
    rd_chk(1, 12'h480, 32'h1234_5678, "R3 cpu txd readback");
    rd_chk(0, 12'h028, 32'h1234_5678, "R5 dbg rxd word");
    rd_chk(0, 12'h02C, 0, "R5 dbg rxs cleared");
    rd_chk(1, 12'h484, 0, "R5 cpu txs cleared");
  endtask

  task automatic t_status_quiet;
    logic [31:0] v;
    wr(0, 12'h020, 32'hCAFE_0002);
    rd(1, 12'h404, v); rd(1, 12'h404, v);
    rd(0, 12'h024, v); rd(0, 12'h020, v);
    rd_chk(1, 12'h404, 1, "R6 flag kept after status reads");
    wr(1, 12'h480, 32'hBEEF_0003);
    rd(0, 12'h02C, v); rd(1, 12'h480, v); rd(1, 12'h484, v);
    rd_chk(0, 12'h02C, 1, "R6 c2d flag kept");
    rd(1, 12'h400, v);
    rd(0, 12'h028, v);
  endtask

  task automatic t_overwrite;
    logic [31:0] v;
    wr(0, 12'h020, 32'h0000_00AA);
    wr(0, 12'h020, 32'h0000_00BB);
    rd_chk(0, 12'h024, 1, "R7 flag still set");
    rd_chk(1, 12'h400, 32'h0000_00BB, "R7 newest word");
    rd_chk(1, 12'h404, 0, "R7 cleared after take");
    wr(1, 12'h480, 32'h0000_0011);
    wr(1, 12'h480, 32'h0000_0022);
    rd_chk(0, 12'h028, 32'h0000_0022, "R7 c2d newest word");
    rd(1, 12'h484, v);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr(0, 12'h020, 32'h1111_1111);
    @(negedge clk);
    dbg_addr = 12'h020; dbg_wdata = 32'h2222_2222; dbg_we = 1'b1;
    cpu_addr = 12'h400; cpu_re = 1'b1;
    #1;
    check("R8 take sees old word", cpu_rdata, 32'h1111_1111);
    @(negedge clk);
    dbg_we = 1'b0; cpu_re = 1'b0;
    rd_chk(1, 12'h404, 1, "R8 write wins flag");
    rd_chk(0, 12'h024, 1, "R8 dbg side flag");
    rd_chk(1, 12'h400, 32'h2222_2222, "R8 new word stored");
    rd(0, 12'h024, v);
  endtask

  task automatic t_readonly;
    wr(0, 12'h024, 32'hFFFF_FFFF);
    wr(0, 12'h028, 32'hFFFF_FFFF);
    wr(0, 12'h02C, 32'hFFFF_FFFF);
    wr(0, 12'h100, 32'hFFFF_FFFF);
    wr(1, 12'h400, 32'hFFFF_FFFF);
    wr(1, 12'h404, 32'hFFFF_FFFF);
    wr(1, 12'h484, 32'hFFFF_FFFF);
    wr(1, 12'h020, 32'hFFFF_FFFF);
    rd_chk(0, 12'h024, 0, "R9 dbg txs untouched");
    rd_chk(0, 12'h02C, 0, "R9 dbg rxs untouched");
    rd_chk(0, 12'h020, 32'h2222_2222, "R9 dbg txd untouched");
    rd_chk(1, 12'h480, 32'h0000_0022, "R9 cpu txd untouched");
  endtask

  task automatic t_unmapped;
    wr(0, 12'h020, 32'h0F0F_0F0F);
    rd_chk(1, 12'h404, 32'h0000_0001, "R10 status upper bits zero");
    rd_chk(0, 12'h100, 0, "R10 dbg unmapped");
    rd_chk(1, 12'h020, 0, "R10 cpu reads dbg address");
    rd_chk(0, 12'h400, 0, "R10 dbg reads cpu address");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dbg_to_cpu();
    t_cpu_to_dbg();
    t_status_quiet();
    t_overwrite();
    t_collision();
    t_readonly();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule